// File: doc/BRIEF.md
# Machine Cycle State Sequencer

This block is the timing backbone of an 8-bit accumulator CPU core. It splits every machine cycle into six states, S1 to S6, that always come in that order. Each state has two phases. The block reports the current state as a one-hot vector and the current phase as two flags. From that position it derives three things: the strobe that latches the opcode into the instruction register, the strobe for the second code fetch, and a one-clock pulse that marks the end of an instruction.

Two machine-cycle lengths are supported. In standard mode a phase lasts one clock, so a machine cycle takes 12 clocks. In fast mode a machine cycle takes 6 clocks: each state lasts one clock and both phase flags are high during it. The decoder supplies a length code that gives how many machine cycles the current instruction takes (1, 2 or 4). The sequencer captures this code at the opcode latch, counts machine cycles, and restarts at S1 of a new instruction after the final cycle.

The block has no data path. All of its pins are plain control and status levels, with no valid/ready handshake and no back-pressure. Reset is synchronous and active high.

Top module: `mcs_sequencer`

## Requirements
- R1: While `rst_i` is high at a clock edge, the block goes to S1, phase 1, machine cycle 0 and loads the cycle mode from `half_mode_i`. After that edge `state_oh_o` is 6'b000001, `opc_latch_o` is high and `instr_done_o` is low.
- R2: With `half_mode_i`=0 (standard mode), each state lasts two clocks: first `ph1_o`=1/`ph2_o`=0, then `ph1_o`=0/`ph2_o`=1. States advance S1→S6, with bit i of `state_oh_o` marking state S(i+1), so a machine cycle is 12 clocks.
- R3: With `half_mode_i`=1 (fast mode), each state lasts one clock with `ph1_o` and `ph2_o` both high, so a machine cycle is 6 clocks.
- R4: `opc_latch_o` is high for every clock of S1 in machine cycle 0 of an instruction and low at all other times.
- R5: `fetch2_o` is high for every clock of S4 in machine cycle 0 of an instruction and low at all other times.
- R6: `len_code_i` is sampled only on the first clock of S1 in machine cycle 0. Codes 2'b00, 2'b01, 2'b10 and 2'b11 mean 1, 2, 4 and 4 machine cycles. A change on `len_code_i` at any other clock has no effect on the current instruction.
- R7: `instr_done_o` is a one-clock pulse on the last clock of S6 in the final machine cycle. On the next clock the block is at S1 phase 1 of machine cycle 0 of the next instruction.
- R8: A change on `half_mode_i` takes effect only at the next machine-cycle boundary. Within a machine cycle the mode stays fixed.
- R9: `mcyc_idx_o` gives the index of the current machine cycle within the instruction. It counts 0 up to N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_i | input | 1 | Synchronous reset, active high |
| half_mode_i | input | 1 | 1 selects the 6-clock machine cycle, 0 the 12-clock one |
| len_code_i | input | 2 | Instruction length code from the decoder |
| state_oh_o | output | 6 | One-hot current state, bit 0 = S1 |
| ph1_o | output | 1 | Phase-1 indication |
| ph2_o | output | 1 | Phase-2 indication |
| mcyc_idx_o | output | 2 | Machine cycle index within the instruction |
| opc_latch_o | output | 1 | Opcode latch strobe (S1 of cycle 0) |
| fetch2_o | output | 1 | Second fetch strobe (S4 of cycle 0) |
| instr_done_o | output | 1 | One-clock end-of-instruction pulse |

## Verification
Every output is decoded from registers with no input in the path. A new input therefore shows up one clock edge after it is applied: reset, the first step of the sequence, and a mode switch at the cycle boundary. The length code shows up only at the end of the instruction, 12·N or 6·N clocks after the opcode clock. The bench drives inputs just after a rising edge and reads outputs one edge later, before the next edge. It numbers clocks from the first clock after reset is released, so clock k of the instruction sits at position k-1 of the expected pattern. The end pulse is compared against the exact clock number computed from the length code and the mode.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  typedef enum logic [1:0] {
    LEN_ONE      = 2'b00,
    LEN_TWO      = 2'b01,
    LEN_FOUR     = 2'b10,
    LEN_FOUR_ALT = 2'b11
  } len_code_e;

  localparam int unsigned MCYC_W = 2;

  // Index of the final machine cycle for a given length code.
  function automatic logic [MCYC_W-1:0] last_mcyc(input len_code_e code);
    case (code)
      LEN_ONE:  return 2'd0;
      LEN_TWO:  return 2'd1;
      default:  return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/mcs_phase_ctr.sv
module mcs_phase_ctr #(
  parameter int unsigned STATES = 6,
  localparam int unsigned ST_W = $clog2(STATES)
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            half_mode_i,
  output logic [ST_W-1:0] st_idx_o,
  output logic            ph_q_o,
  output logic            mode_q_o,
  output logic            first_clk_o,
  output logic            cyc_last_o
);

  localparam logic [ST_W-1:0] LAST_ST = ST_W'(STATES - 1);

  logic [ST_W-1:0] st_q;
  logic            ph_q;
  logic            mode_q;
  logic            state_last;
  logic            cyc_last;

  // A state ends after its second phase, or after its single clock in fast mode.
  assign state_last = mode_q | ph_q;
  assign cyc_last   = state_last && (st_q == LAST_ST);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q   <= '0;
      ph_q   <= 1'b0;
      mode_q <= half_mode_i;
    end else begin
      if (state_last) begin
        st_q <= cyc_last ? '0 : st_q + 1'b1;
      end
      ph_q <= mode_q ? 1'b0 : ~ph_q;
      if (cyc_last) begin
        mode_q <= half_mode_i;
      end
    end
  end

  assign st_idx_o    = st_q;
  assign ph_q_o      = ph_q;
  assign mode_q_o    = mode_q;
  assign first_clk_o = (st_q == '0) && !ph_q;
  assign cyc_last_o  = cyc_last;

endmodule

// File: rtl/mcs_cycle_ctr.sv
module mcs_cycle_ctr
  import mcs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [1:0]        len_code_i,
  input  logic              first_clk_i,
  input  logic              cyc_last_i,
  output logic [MCYC_W-1:0] mcyc_o,
  output logic              done_o
);

  logic [MCYC_W-1:0] mcyc_q;
  len_code_e         len_q;
  logic              done;

  assign done = cyc_last_i && (mcyc_q == last_mcyc(len_q));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mcyc_q <= '0;
      len_q  <= LEN_ONE;
    end else begin
      if (first_clk_i && (mcyc_q == '0)) begin
        len_q <= len_code_e'(len_code_i);
      end
      if (cyc_last_i) begin
        mcyc_q <= done ? '0 : mcyc_q + 1'b1;
      end
    end
  end

  assign mcyc_o = mcyc_q;
  assign done_o = done;

endmodule

// File: rtl/mcs_strobe_dec.sv
module mcs_strobe_dec #(
  parameter int unsigned STATES       = 6,
  parameter int unsigned FETCH2_STATE = 3,
  parameter int unsigned MC_W         = 2,
  localparam int unsigned ST_W = $clog2(STATES)
) (
  input  logic [ST_W-1:0]   st_idx_i,
  input  logic              ph_q_i,
  input  logic              mode_q_i,
  input  logic [MC_W-1:0]   mcyc_i,
  output logic [STATES-1:0] state_oh_o,
  output logic              ph1_o,
  output logic              ph2_o,
  output logic              opc_latch_o,
  output logic              fetch2_o
);

  for (genvar i = 0; i < STATES; i++) begin : g_oh
    assign state_oh_o[i] = (st_idx_i == ST_W'(i));
  end

  logic first_mcyc;
  assign first_mcyc = (mcyc_i == '0);

  assign ph1_o       = mode_q_i | ~ph_q_i;
  assign ph2_o       = mode_q_i | ph_q_i;
  assign opc_latch_o = first_mcyc && (st_idx_i == '0);
  assign fetch2_o    = first_mcyc && (st_idx_i == ST_W'(FETCH2_STATE));

endmodule

// File: rtl/mcs_sequencer.sv
module mcs_sequencer
  import mcs_pkg::*;
#(
  parameter int unsigned STATES       = 6,
  parameter int unsigned FETCH2_STATE = 3
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              half_mode_i,
  input  logic [1:0]        len_code_i,
  output logic [STATES-1:0] state_oh_o,
  output logic              ph1_o,
  output logic              ph2_o,
  output logic [MCYC_W-1:0] mcyc_idx_o,
  output logic              opc_latch_o,
  output logic              fetch2_o,
  output logic              instr_done_o
);

  localparam int unsigned ST_W = $clog2(STATES);

  logic [ST_W-1:0]   st_idx;
  logic              ph_q;
  logic              mode_q;
  logic              first_clk;
  logic              cyc_last;
  logic [MCYC_W-1:0] mcyc;

  mcs_phase_ctr #(.STATES(STATES)) u_phase (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .half_mode_i (half_mode_i),
    .st_idx_o    (st_idx),
    .ph_q_o      (ph_q),
    .mode_q_o    (mode_q),
    .first_clk_o (first_clk),
    .cyc_last_o  (cyc_last)
  );

  mcs_cycle_ctr u_cycle (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .len_code_i  (len_code_i),
    .first_clk_i (first_clk),
    .cyc_last_i  (cyc_last),
    .mcyc_o      (mcyc),
    .done_o      (instr_done_o)
  );

  mcs_strobe_dec #(
    .STATES       (STATES),
    .FETCH2_STATE (FETCH2_STATE),
    .MC_W         (MCYC_W)
  ) u_dec (
    .st_idx_i    (st_idx),
    .ph_q_i      (ph_q),
    .mode_q_i    (mode_q),
    .mcyc_i      (mcyc),
    .state_oh_o  (state_oh_o),
    .ph1_o       (ph1_o),
    .ph2_o       (ph2_o),
    .opc_latch_o (opc_latch_o),
    .fetch2_o    (fetch2_o)
  );

  assign mcyc_idx_o = mcyc;

endmodule

// File: rtl/mcs_sequencer_chk.sv
module mcs_sequencer_chk #(
  parameter int unsigned STATES = 6
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic [STATES-1:0] state_oh_o,
  input logic              ph1_o,
  input logic              ph2_o,
  input logic [1:0]        mcyc_idx_o,
  input logic              opc_latch_o,
  input logic              fetch2_o,
  input logic              instr_done_o
);

  logic last_of_cycle;
  assign last_of_cycle = state_oh_o[STATES-1] && ph2_o;

  a_r2_onehot_state: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones(state_oh_o) == 1);

  a_r2_phase_present: assert property (@(posedge clk_i) disable iff (rst_i)
    ph1_o || ph2_o);

  a_r7_done_in_last_clock: assert property (@(posedge clk_i) disable iff (rst_i)
    instr_done_o |-> last_of_cycle);

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (rst_i)
    instr_done_o |=> !instr_done_o);

  a_r7_restart_after_done: assert property (@(posedge clk_i) disable iff (rst_i)
    instr_done_o |=> (opc_latch_o && ph1_o && mcyc_idx_o == 2'd0));

  a_r2_wrap_to_s1: assert property (@(posedge clk_i) disable iff (rst_i)
    last_of_cycle |=> state_oh_o[0]);

  a_r5_fetch2_place: assert property (@(posedge clk_i) disable iff (rst_i)
    fetch2_o |-> (state_oh_o[3] && mcyc_idx_o == 2'd0));

  a_r4_latch_place: assert property (@(posedge clk_i) disable iff (rst_i)
    opc_latch_o |-> (state_oh_o[0] && mcyc_idx_o == 2'd0));

  a_r8_mode_steady: assert property (@(posedge clk_i) disable iff (rst_i)
    !last_of_cycle |=> $stable(ph1_o && ph2_o));

  a_r9_idx_steady: assert property (@(posedge clk_i) disable iff (rst_i)
    !last_of_cycle |=> $stable(mcyc_idx_o));

endmodule

bind mcs_sequencer mcs_sequencer_chk #(.STATES(STATES)) u_chk (
  .clk_i        (clk_i),
  .rst_i        (rst_i),
  .state_oh_o   (state_oh_o),
  .ph1_o        (ph1_o),
  .ph2_o        (ph2_o),
  .mcyc_idx_o   (mcyc_idx_o),
  .opc_latch_o  (opc_latch_o),
  .fetch2_o     (fetch2_o),
  .instr_done_o (instr_done_o)
);

// File: tb/mcs_sequencer_tb.sv
module mcs_sequencer_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       half_mode = 1'b0;
  logic [1:0] len_code = 2'b00;
  logic [5:0] state_oh;
  logic       ph1, ph2, opc, f2, done;
  logic [1:0] mcyc;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  mcs_sequencer u_dut (
    .clk_i        (clk),
    .rst_i        (rst),
    .half_mode_i  (half_mode),
    .len_code_i   (len_code),
    .state_oh_o   (state_oh),
    .ph1_o        (ph1),
    .ph2_o        (ph2),
    .mcyc_idx_o   (mcyc),
    .opc_latch_o  (opc),
    .fetch2_o     (f2),
    .instr_done_o (done)
  );

  // mode, length code, expected clock number of the end pulse
  typedef struct packed {
    logic       mode;
    logic [1:0] len;
    logic [7:0] clocks;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 2'b00, 8'd12}, '{1'b0, 2'b01, 8'd24},
    '{1'b0, 2'b10, 8'd48}, '{1'b0, 2'b11, 8'd48},
    '{1'b1, 2'b00, 8'd6},  '{1'b1, 2'b01, 8'd12},
    '{1'b1, 2'b10, 8'd24}, '{1'b1, 2'b11, 8'd24}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic m);
    rst = 1'b1;
    half_mode = m;
    step();
    step();
    rst = 1'b0;
  endtask

  // Count clocks from clock 1 of an instruction until the end pulse.
  task automatic run_instr(input logic m, output int n, output int pos_err,
                           output int opc_cnt, output int f2_cnt, output int f2_first);
    int cyc;
    cyc = m ? 6 : 12;
    n = 1; pos_err = 0; opc_cnt = 0; f2_cnt = 0; f2_first = 0;
    forever begin
      int k, st, ph, mi;
      k  = (n - 1) % cyc;
      mi = (n - 1) / cyc;
      st = m ? k : k / 2;
      ph = k % 2;
      if (state_oh != (6'b1 << st)) pos_err++;
      if (m ? !(ph1 && ph2) : (ph1 != (ph == 0) || ph2 != (ph == 1))) pos_err++;
      if (mcyc != 2'(mi)) pos_err++;
      if (opc) opc_cnt++;
      if (f2) begin
        f2_cnt++;
        if (f2_first == 0) f2_first = n;
      end
      if (done || n >= 100) break;
      step();
      n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n, pe, oc, fc, ff;

    // R1: reset state
    do_reset(1'b0);
    chk(state_oh == 6'b000001 && ph1 && !ph2, "R1 state", int'(state_oh), 1);
    chk(opc && !done && !f2 && mcyc == 2'd0, "R1 strobes", int'({opc, done, f2}), 4);

    // Table walk: R2 R3 R6 R7 R9
    foreach (VECS[i]) begin
      do_reset(VECS[i].mode);
      len_code = VECS[i].len;
      run_instr(VECS[i].mode, n, pe, oc, fc, ff);
      chk(n == int'(VECS[i].clocks), "R6 R7 end clock", n, int'(VECS[i].clocks));
      chk(pe == 0, VECS[i].mode ? "R3 R9 sequence" : "R2 R9 sequence", pe, 0);
    end

    // R4 R5: strobe widths and placement, standard mode, two cycles
    do_reset(1'b0);
    len_code = 2'b01;
    run_instr(1'b0, n, pe, oc, fc, ff);
    chk(oc == 2, "R4 latch clocks", oc, 2);
    chk(fc == 2, "R5 fetch2 clocks", fc, 2);
    chk(ff == 7, "R5 fetch2 start", ff, 7);

    // R4 R5 in fast mode, four cycles
    do_reset(1'b1);
    len_code = 2'b10;
    run_instr(1'b1, n, pe, oc, fc, ff);
    chk(oc == 1 && fc == 1, "R4 R5 fast strobes", oc * 10 + fc, 11);
    chk(ff == 4, "R5 fast fetch2 start", ff, 4);

    // R6: change after the opcode clock is ignored; next instruction samples anew
    do_reset(1'b0);
    len_code = 2'b01;
    step();
    len_code = 2'b10;
    chk(!done, "R6 no early end", int'(done), 0);
    run_instr(1'b0, n, pe, oc, fc, ff);
    chk(n == 23, "R6 ignored late code", n + 1, 24);
    step();
    // R7: back at S1 of a new instruction
    chk(state_oh == 6'b000001 && ph1 && !ph2 && opc && mcyc == 2'd0 && !done,
        "R7 restart", int'(state_oh), 1);
    run_instr(1'b0, n, pe, oc, fc, ff);
    chk(n == 48, "R6 new code sampled", n, 48);

    // R8: mode request mid-cycle waits for boundary
    do_reset(1'b0);
    len_code = 2'b00;
    step();
    step();
    half_mode = 1'b1;
    step();
    chk(ph1 != ph2, "R8 mode held mid cycle", int'({ph1, ph2}), 1);
    repeat (8) step();
    chk(state_oh == 6'b100000 && ph2 && !ph1 && done, "R8 standard end",
        int'(state_oh), 32);
    step();
    chk(state_oh == 6'b000001 && ph1 && ph2, "R8 fast after boundary",
        int'({ph1, ph2}), 3);
    run_instr(1'b1, n, pe, oc, fc, ff);
    chk(n == 6 && pe == 0, "R8 fast cycle length", n, 6);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule